// File: doc/BRIEF.md
# Elastic Bit Store with Pointer-Separation Alarm

This block is a one-bit-wide elastic store for a jitter-smoothing path. Serial bits are written on the line clock and read out on a separate, smoothed read clock. Both pointers cross between the clock domains as Gray code. The read domain computes the pointer separation (the number of bits held) and uses it to raise sticky overflow and underrun error flags. It also raises a near-collision limit alarm when the separation comes within two bit positions of either end.

Software reaches the block through a small byte-wide register port on the read clock. There are three registers. The control byte holds a self-clearing pointer re-centre bit, a receive/transmit path select, a diagnostic bit that forces the limit alarm, and a two-bit mode field. The mode field selects a 16-bit depth, a 32-bit depth or a bypass mode. The alarm status byte is read-only. The interrupt status byte clears when read. Every change of the limit alarm latches an interrupt bit, and the block drives an active-low interrupt request while that bit is set.

Top module: `ebfElasticStore`

## Requirements
- R1: After reset, the control byte (address 0), the alarm byte (address 1) and the interrupt byte (address 2) all read 0x00, irqN is 1 and pathTx is 0. The store then holds half its depth of zero bits.
- R2: Accepted bits leave on rdData in the order they were written. Each one is marked by a one-cycle rdValid pulse. No bit is lost or duplicated while the store is neither empty nor full.
- R3: The store refuses a read while the read domain sees zero bits held. When the separation reaches zero, alarm byte bit 0 (underrun) becomes 1 and stays set.
- R4: The store refuses a write while it is full. When the held count reaches the depth, alarm byte bit 1 (overflow) becomes 1 and stays set.
- R5: Alarm byte bit 3 reads 1 while the held count is at most 2 or at least the depth minus 2. Otherwise it reads 0.
- R6: Every change of alarm bit 3, rising or falling, sets interrupt byte bit 3. irqN is 0 whenever that bit is set.
- R7: A read of address 2 returns the interrupt byte and clears bit 3, which releases irqN. If a fresh change of the limit alarm arrives in the same cycle, the bit stays set.
- R8: Writing 1 to control bit 3 re-centres the store to half its depth in both clock domains and clears alarm bits 1 and 0. Control bit 3 always reads 0.
- R9: The mode field is {control bit 2, control bit 0}. 00 selects a 16-bit depth and 01 selects a 32-bit depth. Any write that changes the mode also re-centres the store.
- R10: Mode 1x is bypass. rdData follows wrData through a synchroniser, rdValid follows rdEn, the pointers are frozen, and no limit, overflow or underrun is raised.
- R11: Control bit 1 selects the path (0 receive, 1 transmit) and drives pathTx. Bits 7, 6 and 5 read 0.
- R12: Control bit 4 forces alarm bit 3 to 1 while it is set, whatever the held count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write (line) clock |
| wrRstN | input | 1 | Active-low asynchronous reset, write domain |
| wrEn | input | 1 | Write one bit this cycle |
| wrData | input | 1 | Serial data in |
| rdClk | input | 1 | Smoothed read clock; also clocks the register port |
| rdRstN | input | 1 | Active-low asynchronous reset, read domain |
| rdEn | input | 1 | Request one bit this cycle |
| rdData | output | 1 | Serial data out |
| rdValid | output | 1 | rdData carries a bit read this cycle |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (read of address 2 clears) |
| regAddr | input | 2 | Register address: 0 control, 1 alarm, 2 interrupt |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data, combinational from regAddr |
| irqN | output | 1 | Active-low interrupt request |
| pathTx | output | 1 | Path select: 1 transmit, 0 receive |

## Verification
A corrupted pointer or a wrong Gray conversion shows up at the ports within a few bits. The scoreboard sees rdData out of order, or rdValid with nothing expected. A wrong depth or re-centre point moves the cycle in which alarm bit 3 and the error bits appear, and the bench pins this down by filling and draining to exact counts around both thresholds. A latch that fails to set or clear shows on irqN and on the interrupt byte one register read later.

// File: rtl/ebfPkg.sv
`timescale 1ns/1ps
package ebfPkg;

  // Strobes from the register/alarm control to the pointer datapath (read domain)
  typedef struct packed {
    logic ptrReset;   // one-cycle re-centre request
    logic holdRead;   // reads and alarm evaluation suspended after re-centre
    logic bypass;     // mode 1x
    logic deep;       // mode 01 (32-bit depth)
  } ebfStrobesT;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_ALARM = 2'd1;
  localparam logic [1:0] ADDR_INT   = 2'd2;

endpackage

// File: rtl/ebfDatapath.sv
`timescale 1ns/1ps
module ebfDatapath
  import ebfPkg::*;
#(
  parameter int MAX_DEPTH   = 32,
  parameter int SYNC_STAGES = 2,
  parameter int PTR_W       = $clog2(MAX_DEPTH) + 1
) (
  input  logic             wrClk,
  input  logic             wrRstN,
  input  logic             wrEn,
  input  logic             wrData,
  input  logic             rdClk,
  input  logic             rdRstN,
  input  logic             rdEn,
  input  ebfStrobesT       strobes,
  output logic             rdData,
  output logic             rdValid,
  output logic [PTR_W-1:0] fill
);

  localparam int ADDR_W = PTR_W - 1;
  localparam logic [PTR_W-1:0] DEPTH_HI = PTR_W'(MAX_DEPTH);
  localparam logic [PTR_W-1:0] DEPTH_LO = PTR_W'(MAX_DEPTH / 2);
  localparam logic [PTR_W-1:0] RST_CENTRE = DEPTH_LO >> 1;

  function automatic logic [PTR_W-1:0] toGray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] fromGray(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [MAX_DEPTH-1:0] storeBits;

  // ---------------- read-domain state visible to write side ----------------
  logic             rstToggle;
  logic [PTR_W-1:0] rptrBin, rptrGray;

  // ---------------- write domain ----------------
  logic [SYNC_STAGES-1:0] tglSync;
  logic                   tglSeen;
  logic [1:0]             modeSync [SYNC_STAGES];
  logic [PTR_W-1:0]       rGraySync [SYNC_STAGES];
  logic [PTR_W-1:0]       wptrBin, wptrGray, wptrNext;
  logic                   wrDataQ;

  logic             wDeep, wBypass, wrRecenter, wrFull, wrAccept;
  logic [PTR_W-1:0] wrDepth, wrUsed, rBinW;
  logic [ADDR_W-1:0] wrMask;

  always_comb begin
    wDeep      = modeSync[SYNC_STAGES-1][1];
    wBypass    = modeSync[SYNC_STAGES-1][0];
    wrDepth    = wDeep ? DEPTH_HI : DEPTH_LO;
    wrMask     = ADDR_W'(wrDepth - 1'b1);
    wrRecenter = tglSync[SYNC_STAGES-1] ^ tglSeen;
    rBinW      = fromGray(rGraySync[SYNC_STAGES-1]);
    wrUsed     = wptrBin - rBinW;
    wrFull     = wrUsed >= wrDepth;
    wrAccept   = wrEn && !wrFull && !wBypass && !wrRecenter;
    if (wrRecenter)    wptrNext = wrDepth >> 1;
    else if (wrAccept) wptrNext = wptrBin + 1'b1;
    else               wptrNext = wptrBin;
  end

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      tglSync   <= '0;
      tglSeen   <= 1'b0;
      for (int s = 0; s < SYNC_STAGES; s++) begin
        modeSync[s]  <= 2'b00;
        rGraySync[s] <= '0;
      end
      wptrBin   <= RST_CENTRE;
      wptrGray  <= toGray(RST_CENTRE);
      storeBits <= '0;
      wrDataQ   <= 1'b0;
    end else begin
      tglSync      <= {tglSync[SYNC_STAGES-2:0], rstToggle};
      tglSeen      <= tglSync[SYNC_STAGES-1];
      modeSync[0]  <= {strobes.deep, strobes.bypass};
      rGraySync[0] <= rptrGray;
      for (int s = 1; s < SYNC_STAGES; s++) begin
        modeSync[s]  <= modeSync[s-1];
        rGraySync[s] <= rGraySync[s-1];
      end
      if (wrAccept) storeBits[wptrBin[ADDR_W-1:0] & wrMask] <= wrData;
      wptrBin  <= wptrNext;
      wptrGray <= toGray(wptrNext);
      wrDataQ  <= wrData;
    end
  end

  // ---------------- read domain ----------------
  logic [PTR_W-1:0]       wGraySync [SYNC_STAGES];
  logic [SYNC_STAGES-1:0] dataSync;
  logic [PTR_W-1:0]       rptrNext, wBinR, rdDepth;
  logic [ADDR_W-1:0]      rdMask;
  logic                   readOk;

  always_comb begin
    wBinR   = fromGray(wGraySync[SYNC_STAGES-1]);
    fill    = wBinR - rptrBin;
    rdDepth = strobes.deep ? DEPTH_HI : DEPTH_LO;
    rdMask  = ADDR_W'(rdDepth - 1'b1);
    readOk  = rdEn && !strobes.ptrReset && !strobes.holdRead &&
              !strobes.bypass && (fill != '0);
    if (strobes.ptrReset) rptrNext = '0;
    else if (readOk)      rptrNext = rptrBin + 1'b1;
    else                  rptrNext = rptrBin;
  end

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      rstToggle <= 1'b0;
      rptrBin   <= '0;
      rptrGray  <= '0;
      for (int s = 0; s < SYNC_STAGES; s++) wGraySync[s] <= '0;
      dataSync  <= '0;
      rdData    <= 1'b0;
      rdValid   <= 1'b0;
    end else begin
      if (strobes.ptrReset) rstToggle <= ~rstToggle;
      rptrBin      <= rptrNext;
      rptrGray     <= toGray(rptrNext);
      wGraySync[0] <= wptrGray;
      for (int s = 1; s < SYNC_STAGES; s++) wGraySync[s] <= wGraySync[s-1];
      dataSync <= {dataSync[SYNC_STAGES-2:0], wrDataQ};
      if (strobes.bypass) begin
        rdData  <= dataSync[SYNC_STAGES-1];
        rdValid <= rdEn;
      end else begin
        if (readOk) rdData <= storeBits[rptrBin[ADDR_W-1:0] & rdMask];
        rdValid <= readOk;
      end
    end
  end

endmodule

// File: rtl/ebfControl.sv
`timescale 1ns/1ps
module ebfControl
  import ebfPkg::*;
#(
  parameter int MAX_DEPTH   = 32,
  parameter int PTR_W       = $clog2(MAX_DEPTH) + 1,
  parameter int LIMIT_GAP   = 2,
  parameter int HOLD_CYCLES = 12
) (
  input  logic             rdClk,
  input  logic             rdRstN,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic [1:0]       regAddr,
  input  logic [7:0]       regWrData,
  input  logic [PTR_W-1:0] fill,
  output logic [7:0]       regRdData,
  output logic             irqN,
  output logic             pathTx,
  output ebfStrobesT       strobes,
  output logic [7:0]       ctrlByte,
  output logic [7:0]       alarmByte,
  output logic [7:0]       intByte
);

  localparam int HOLD_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [PTR_W-1:0] DEPTH_HI = PTR_W'(MAX_DEPTH);
  localparam logic [PTR_W-1:0] DEPTH_LO = PTR_W'(MAX_DEPTH / 2);
  localparam logic [PTR_W-1:0] GAP      = PTR_W'(LIMIT_GAP);

  logic              pathSel, forceLim, limitReg, ovfFlag, udfFlag, limChg;
  logic [1:0]        mode;
  logic [HOLD_W-1:0] holdCnt;

  logic             ctrlWr, ptrResetReq, intClear, active, limitNext;
  logic [1:0]       newMode;
  logic [PTR_W-1:0] depth;

  always_comb begin
    ctrlWr      = regWrEn && (regAddr == ADDR_CTRL);
    newMode     = {regWrData[2], regWrData[0]};
    ptrResetReq = ctrlWr && (regWrData[3] || (newMode != mode));
    intClear    = regRdEn && (regAddr == ADDR_INT);

    strobes.ptrReset = ptrResetReq;
    strobes.holdRead = holdCnt != '0;
    strobes.bypass   = mode[1];
    strobes.deep     = !mode[1] && mode[0];

    depth     = strobes.deep ? DEPTH_HI : DEPTH_LO;
    active    = !strobes.bypass && !strobes.holdRead;
    limitNext = forceLim || (active && ((fill <= GAP) || (fill >= depth - GAP)));
  end

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      pathSel  <= 1'b0;
      forceLim <= 1'b0;
      mode     <= 2'b00;
      holdCnt  <= HOLD_W'(HOLD_CYCLES);
      limitReg <= 1'b0;
      ovfFlag  <= 1'b0;
      udfFlag  <= 1'b0;
      limChg   <= 1'b0;
    end else begin
      if (ctrlWr) begin
        pathSel  <= regWrData[1];
        forceLim <= regWrData[4];
        mode     <= newMode;
      end
      if (ptrResetReq)            holdCnt <= HOLD_W'(HOLD_CYCLES);
      else if (holdCnt != '0)     holdCnt <= holdCnt - 1'b1;

      if (ptrResetReq) begin
        ovfFlag <= 1'b0;
        udfFlag <= 1'b0;
      end else if (active) begin
        if (fill == '0)    udfFlag <= 1'b1;
        if (fill >= depth) ovfFlag <= 1'b1;
      end

      limitReg <= limitNext;
      if (limitNext != limitReg) limChg <= 1'b1;
      else if (intClear)         limChg <= 1'b0;
    end
  end

  always_comb begin
    ctrlByte  = {3'b000, forceLim, 1'b0, mode[1], pathSel, mode[0]};
    alarmByte = {4'b0000, limitReg, 1'b0, ovfFlag, udfFlag};
    intByte   = {4'b0000, limChg, 3'b000};
    unique case (regAddr)
      ADDR_CTRL:  regRdData = ctrlByte;
      ADDR_ALARM: regRdData = alarmByte;
      ADDR_INT:   regRdData = intByte;
      default:    regRdData = 8'h00;
    endcase
    irqN   = !limChg;
    pathTx = pathSel;
  end

endmodule

// File: rtl/ebfElasticStore.sv
`timescale 1ns/1ps
module ebfElasticStore
  import ebfPkg::*;
#(
  parameter int MAX_DEPTH   = 32,
  parameter int SYNC_STAGES = 2,
  parameter int LIMIT_GAP   = 2,
  parameter int HOLD_CYCLES = 12,
  parameter int PTR_W       = $clog2(MAX_DEPTH) + 1
) (
  input  logic       wrClk,
  input  logic       wrRstN,
  input  logic       wrEn,
  input  logic       wrData,
  input  logic       rdClk,
  input  logic       rdRstN,
  input  logic       rdEn,
  output logic       rdData,
  output logic       rdValid,
  input  logic       regWrEn,
  input  logic       regRdEn,
  input  logic [1:0] regAddr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  output logic       irqN,
  output logic       pathTx
);

  ebfStrobesT       strobes;
  logic [PTR_W-1:0] fill;
  logic [7:0]       ctrlByte, alarmByte, intByte;

  ebfDatapath #(
    .MAX_DEPTH(MAX_DEPTH), .SYNC_STAGES(SYNC_STAGES), .PTR_W(PTR_W)
  ) datapath_i (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrEn(wrEn), .wrData(wrData),
    .rdClk(rdClk), .rdRstN(rdRstN), .rdEn(rdEn), .strobes(strobes),
    .rdData(rdData), .rdValid(rdValid), .fill(fill)
  );

  ebfControl #(
    .MAX_DEPTH(MAX_DEPTH), .PTR_W(PTR_W),
    .LIMIT_GAP(LIMIT_GAP), .HOLD_CYCLES(HOLD_CYCLES)
  ) control_i (
    .rdClk(rdClk), .rdRstN(rdRstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .fill(fill),
    .regRdData(regRdData), .irqN(irqN), .pathTx(pathTx), .strobes(strobes),
    .ctrlByte(ctrlByte), .alarmByte(alarmByte), .intByte(intByte)
  );

endmodule

// File: rtl/ebfChecker.sv
`timescale 1ns/1ps
module ebfChecker
  import ebfPkg::*;
#(
  parameter int MAX_DEPTH = 32,
  parameter int PTR_W     = $clog2(MAX_DEPTH) + 1
) (
  input logic             rdClk,
  input logic             rdRstN,
  input logic             irqN,
  input logic             rdValid,
  input logic [PTR_W-1:0] fill,
  input ebfStrobesT       strobes,
  input logic [7:0]       ctrlByte,
  input logic [7:0]       alarmByte
);

  localparam logic [PTR_W-1:0] DEPTH_HI = PTR_W'(MAX_DEPTH);
  localparam logic [PTR_W-1:0] DEPTH_LO = PTR_W'(MAX_DEPTH / 2);

  // A change of the limit alarm must already be pulling the request line low
  assert_irq_on_limit_change_R6: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (alarmByte[3] != $past(alarmByte[3])) |-> !irqN);

  // A bit may only come out of the store if the read side saw data the cycle before
  assert_read_needs_data_R3: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (rdValid && !$past(strobes.bypass)) |-> ($past(fill) != '0));

  // Held count never exceeds the selected depth outside the re-centre window
  assert_fill_bounded_R4: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (!strobes.holdRead && !strobes.bypass) |->
      (fill <= (strobes.deep ? DEPTH_HI : DEPTH_LO)));

  // A re-centre leaves both error flags clear on the next cycle
  assert_reset_clears_errors_R8: assert property (@(posedge rdClk) disable iff (!rdRstN)
    strobes.ptrReset |=> (alarmByte[1:0] == 2'b00));

  // Bypass with no forcing raises no limit alarm
  assert_bypass_quiet_R10: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (strobes.bypass && !ctrlByte[4]) |=> !alarmByte[3]);

endmodule

bind ebfElasticStore ebfChecker #(.MAX_DEPTH(MAX_DEPTH), .PTR_W(PTR_W)) checker_i (
  .rdClk(rdClk), .rdRstN(rdRstN), .irqN(irqN), .rdValid(rdValid), .fill(fill),
  .strobes(strobes), .ctrlByte(ctrlByte), .alarmByte(alarmByte)
);

// File: tb/ebfElasticStore_tb_top.sv
`timescale 1ns/1ps
module ebfElasticStore_tb_top;

  logic       wrClk = 1'b0, rdClk = 1'b0;
  logic       wrRstN = 1'b0, rdRstN = 1'b0;
  logic       wrEn = 1'b0, wrData = 1'b0, rdEn = 1'b0;
  logic       regWrEn = 1'b0, regRdEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWrData = 8'h00;
  logic       rdData, rdValid, irqN, pathTx;
  logic [7:0] regRdData;

  int checks = 0;
  int fails  = 0;
  bit monOn  = 1'b0;
  bit finished = 1'b0;
  int expQ[$];   // 0/1 = expected bit, 2 = stale bit, not compared

  always #2 rdClk = ~rdClk;                       // 250 MHz
  initial begin #1; forever #2 wrClk = ~wrClk; end

  ebfElasticStore dut_i (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrEn(wrEn), .wrData(wrData),
    .rdClk(rdClk), .rdRstN(rdRstN), .rdEn(rdEn),
    .rdData(rdData), .rdValid(rdValid),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .irqN(irqN), .pathTx(pathTx)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected bits as the store emits them (R2)
  always @(negedge rdClk) begin
    if (monOn && rdValid) begin
      checks++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL R2/R3 bit emitted with nothing expected actual=%0d expected=none", rdData);
      end else begin
        int e;
        e = expQ.pop_front();
        if (e != 2 && int'(rdData) != e) begin
          fails++;
          $display("FAIL R2 data order actual=%0d expected=%0d", rdData, e);
        end
      end
    end
  end

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge rdClk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge rdClk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge rdClk);
    regRdEn = 1'b1; regAddr = a;
    #0.5 d = regRdData;
    @(negedge rdClk);
    regRdEn = 1'b0;
  endtask

  task automatic rdWait(input int n);
    repeat (n) @(negedge rdClk);
  endtask

  // Driver: writes n random bits, queueing the first nPush as expected
  task automatic writeBits(input int n, input int nPush);
    for (int i = 0; i < n; i++) begin
      @(negedge wrClk);
      wrEn = 1'b1; wrData = 1'($urandom() & 1);
      if (i < nPush) expQ.push_back(int'(wrData));
    end
    @(negedge wrClk);
    wrEn = 1'b0;
  endtask

  task automatic pushStale(input int n);
    for (int i = 0; i < n; i++) expQ.push_back(2);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge rdClk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (5) @(negedge rdClk);
    wrRstN = 1'b1; rdRstN = 1'b1;
    rdWait(20);

    // R1 reset state
    regRead(2'd0, v); check("R1 control byte", v, 8'h00);
    regRead(2'd1, v); check("R1 alarm byte", v, 8'h00);
    regRead(2'd2, v); check("R1 interrupt byte", v, 8'h00);
    check("R1 irqN", {7'd0, irqN}, 8'h01);
    check("R1 pathTx", {7'd0, pathTx}, 8'h00);

    // R2 streaming: 8 preloaded zeros then written bits in order
    for (int i = 0; i < 8; i++) expQ.push_back(0);
    monOn = 1'b1;
    fork
      writeBits(100, 100);
      begin @(negedge rdClk); rdEn = 1'b1; end
    join
    rdWait(40);                         // drain to empty (R3)
    rdEn = 1'b0;
    rdWait(4);
    check("R2 all bits drained", 8'(expQ.size()), 8'h00);
    regRead(2'd1, v); check("R3 R5 underrun and limit", v, 8'h09);
    check("R6 irqN low on limit change", {7'd0, irqN}, 8'h00);
    regRead(2'd2, v); check("R6 interrupt bit set", v, 8'h08);
    check("R7 irqN released after read", {7'd0, irqN}, 8'h01);
    regRead(2'd2, v); check("R7 interrupt bit cleared", v, 8'h00);

    // R8 pointer re-centre
    regWrite(2'd0, 8'h08);
    rdWait(30);
    regRead(2'd0, v); check("R8 reset bit self-clears", v, 8'h00);
    regRead(2'd1, v); check("R8 errors cleared, centred", v, 8'h00);
    regRead(2'd2, v); check("R6 falling limit interrupts", v, 8'h08);
    expQ.delete(); pushStale(8);

    // R4 overflow at depth 16: only 8 of 12 writes accepted
    writeBits(12, 8);
    rdWait(20);
    regRead(2'd1, v); check("R4 R5 overflow and limit", v, 8'h0A);
    regRead(2'd2, v); check("R6 rising limit interrupts", v, 8'h08);
    @(negedge rdClk); rdEn = 1'b1;
    rdWait(30);
    rdEn = 1'b0; rdWait(4);
    check("R4 exactly 16 bits held", 8'(expQ.size()), 8'h00);
    regRead(2'd1, v); check("R3 R4 sticky errors", v, 8'h0B);
    regRead(2'd2, v);

    // R9 32-bit depth via mode change (auto re-centre to 16)
    regWrite(2'd0, 8'h01);
    rdWait(30);
    regRead(2'd0, v); check("R9 mode readback", v, 8'h01);
    regRead(2'd1, v); check("R9 re-centre on mode change", v, 8'h00);
    regRead(2'd2, v);
    expQ.delete(); pushStale(16);
    writeBits(12, 12); rdWait(20);
    regRead(2'd1, v); check("R9 28 of 32 held, no alarm", v, 8'h00);
    writeBits(2, 2); rdWait(20);
    regRead(2'd1, v); check("R5 limit at depth-2", v, 8'h08);
    writeBits(2, 2); rdWait(20);
    regRead(2'd1, v); check("R4 overflow at 32", v, 8'h0A);
    @(negedge rdClk); rdEn = 1'b1;
    rdWait(50);
    rdEn = 1'b0; rdWait(4);
    check("R9 32 bits drained in order", 8'(expQ.size()), 8'h00);
    regRead(2'd1, v); check("R9 errors after drain", v, 8'h0B);

    // R12 forced limit
    regWrite(2'd0, 8'h09);
    rdWait(30);
    regRead(2'd1, v); check("R8 explicit re-centre", v, 8'h00);
    regRead(2'd2, v);
    regWrite(2'd0, 8'h11); rdWait(4);
    regRead(2'd1, v); check("R12 force sets limit", v, 8'h08);
    check("R12 force raises irq", {7'd0, irqN}, 8'h00);
    regWrite(2'd0, 8'h01); rdWait(4);
    regRead(2'd1, v); check("R12 force released", v, 8'h00);
    regRead(2'd2, v);

    // R11 path select and unused bit
    regWrite(2'd0, 8'h83);
    regRead(2'd0, v); check("R11 bit7 reads 0, path set", v, 8'h03);
    check("R11 pathTx high", {7'd0, pathTx}, 8'h01);
    regWrite(2'd0, 8'h01);
    check("R11 pathTx low", {7'd0, pathTx}, 8'h00);

    // R10 bypass
    monOn = 1'b0;
    regWrite(2'd0, 8'h04);
    rdWait(30);
    regRead(2'd0, v); check("R10 bypass mode readback", v, 8'h04);
    regRead(2'd2, v);
    @(negedge wrClk); wrData = 1'b1;
    @(negedge rdClk); rdEn = 1'b1;
    rdWait(12);
    check("R10 data follows high", {7'd0, rdData}, 8'h01);
    check("R10 valid follows rdEn", {7'd0, rdValid}, 8'h01);
    @(negedge wrClk); wrData = 1'b0;
    rdWait(12);
    check("R10 data follows low", {7'd0, rdData}, 8'h00);
    regRead(2'd1, v); check("R10 no alarms in bypass", v, 8'h00);
    rdEn = 1'b0;

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule